// File: doc/BRIEF.md
# Serial Command-Register Interface Controller

This block is the serial slave port of a converter's register bank. An external master drives a serial clock, a data line and an active-low select. Every exchange opens with an 8-bit command byte, sent most significant bit first. The command names a 3-bit register address, the direction, and an optional continuous-read request. A data transfer follows, and its length is fixed by the register: 8, 16 or 24 bits. Registers that can be written also drive a parallel port into the rest of the chip. The conversion engine sits outside the block. It is modelled as a one-cycle done strobe together with a 24-bit result.

The block runs on a single system clock. The serial clock is sampled and turned into edge strobes. The data input is taken on serial-clock rising edges, and the data output moves only after falling edges. The serial clock idles high.

The controller states are:
- `ST_CMD`: collecting a command.
- `ST_RD`: shifting a register out.
- `ST_WR`: shifting a register in.
- `ST_CRD`: continuous read.

The transitions are:
- `ST_CMD` to `ST_RD` on a completed read command.
- `ST_CMD` to `ST_WR` on a completed write command to a nonzero address.
- `ST_CMD` to `ST_CRD` on the exact byte 0x5C.
- `ST_RD` or `ST_WR` back to `ST_CMD` on the last bit of the transfer.
- `ST_CRD` to `ST_CMD` on the exit byte 0x58 while a result is pending.
- Any state to `ST_CMD` on 32 consecutive ones on the data line.
- `ST_RD` or `ST_WR` to `ST_CMD` when select is released.

Top module: `sif_cmd_port`

## Requirements
- R1: In command wait, a data-line 1 in the first command position is ignored and the interface keeps waiting. After the first 0, the next seven bits form command bits 6 down to 0: bit 6 is 1 for a read and 0 for a write, bits 5:3 are the register address, and bit 2 requests continuous read.
- R2: Transfer lengths by address are: 0 = 8 bits, 1 = 16, 2 = 16, 3 = 24, 4 = 8, 5 = 8, 6 = 24, 7 = 24. Data moves MSB first. `sdi` is taken on rising `sclk` edges. Read data for the first bit is on `sdo` after the falling edge that follows the command's last rising edge.
- R3: Addresses 1, 2, 6 and 7 are writable. A completed write updates `mode_q`, `cfg_q`, `ofs_q` or `fs_q` respectively, and a read of the same address returns the written value.
- R4: Reads of read-only addresses return fixed contents. Address 0 returns {`rdy_n`, 7'b0}, address 4 returns `ID_VALUE`, and address 5 returns 0. A write to address 3, 4 or 5 consumes its full length and changes nothing. A write command to address 0 carries no data, and the next byte is a new command.
- R5: `conv_done` loads `conv_result` into the data register (address 3) and drives `rdy_n` low. `rdy_n` returns high when a complete read of address 3 finishes, and also on any completed write to address 1.
- R6: The exact command byte 0x5C enters continuous read. From then on, each time `rdy_n` is low, the next 24 `sclk` pulses shift the result out MSB first with no command. `rdy_n` goes high after the 24th rising edge.
- R7: In continuous read, the eight most recent `sdi` bits are watched. If they equal 0x58 at a rising edge while `rdy_n` is low, the interface returns to command wait. The same byte while `rdy_n` is high has no effect.
- R8: 32 consecutive rising `sclk` edges with `sdi` high and `cs_n` low restore the power-on state in any state, including continuous read. Thirty-one ones followed by a zero do not.
- R9: The power-on state is: status 0x80, `mode_q` 0x000A, `cfg_q` 0x0010, `ofs_q` 0x800000, `fs_q` 0x500000, `rdy_n` high, command wait.
- R10: Raising `cs_n` during a partial command or transfer abandons it, changes no register, and leaves the interface in command wait. While `cs_n` is high, no register changes.
- R11: `sdo` changes only in the system-clock cycle that registers a falling `sclk` edge taken while `cs_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the master, idles high |
| cs_n | input | 1 | Active-low select |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| conv_done | input | 1 | One-cycle strobe: a new result is available |
| conv_result | input | 24 | Result word captured on `conv_done` |
| rdy_n | output | 1 | Low while an unread result is held |
| mode_q | output | 16 | Mode register contents |
| cfg_q | output | 16 | Configuration register contents |
| ofs_q | output | 24 | Offset register contents |
| fs_q | output | 24 | Full-scale register contents |

## Verification
A bit counter off by one in the command phase shows up on the first access. A read then returns the wrong register, or the read data comes out shifted by one place on `sdo`. A missed return to `ST_CMD` garbles every later exchange, and a readback of the ID register exposes it within the next command. A wrong ready or continuous-read state appears at `rdy_n`, or as a frame of zeros in place of the result, within one 24-bit frame. A broken ones counter shows as registers that fail to revert, or that revert too early, at the 32nd or 31st bit.

// File: rtl/sif_pkg.sv
`timescale 1ns/1ps
package sif_pkg;
    localparam int DW    = 24;
    localparam int AW    = 3;
    localparam int CNT_W = $clog2(DW) + 1;

    typedef enum logic [1:0] {ST_CMD, ST_RD, ST_WR, ST_CRD} sif_state_e;

    localparam logic [AW-1:0] A_STAT = 3'd0;
    localparam logic [AW-1:0] A_MODE = 3'd1;
    localparam logic [AW-1:0] A_CFG  = 3'd2;
    localparam logic [AW-1:0] A_DATA = 3'd3;
    localparam logic [AW-1:0] A_ID   = 3'd4;
    localparam logic [AW-1:0] A_OFS  = 3'd6;
    localparam logic [AW-1:0] A_FS   = 3'd7;

    localparam logic [7:0] CRD_EXIT = 8'h58;

    // transfer length in bits for each register address
    function automatic logic [CNT_W-1:0] reg_len(input logic [AW-1:0] a);
        case (a)
            A_MODE, A_CFG:       reg_len = CNT_W'(16);
            A_DATA, A_OFS, A_FS: reg_len = CNT_W'(24);
            default:             reg_len = CNT_W'(8);
        endcase
    endfunction
endpackage

// File: rtl/sif_edge.sv
`timescale 1ns/1ps
module sif_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    output logic rise,
    output logic fall
);
    logic sclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_q <= 1'b1;
        else        sclk_q <= sclk;
    end

    assign rise = sclk & ~sclk_q;
    assign fall = ~sclk & sclk_q;
endmodule

// File: rtl/sif_ones_watch.sv
`timescale 1ns/1ps
module sif_ones_watch #(
    parameter int LIMIT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    input  logic cs_n,
    input  logic sdi,
    output logic wipe
);
    localparam int CW = $clog2(LIMIT) + 1;
    logic [CW-1:0] run;

    assign wipe = rise && !cs_n && sdi && (run == CW'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          run <= '0;
        else if (cs_n || wipe) run <= '0;
        else if (rise)       run <= sdi ? run + CW'(1) : '0;
    end
endmodule

// File: rtl/sif_regbank.sv
`timescale 1ns/1ps
module sif_regbank
    import sif_pkg::*;
#(
    parameter logic [7:0]    ID_VALUE = 8'hA7,
    parameter logic [15:0]   MODE_RST = 16'h000A,
    parameter logic [15:0]   CFG_RST  = 16'h0010,
    parameter logic [DW-1:0] OFS_RST  = 24'h800000,
    parameter logic [DW-1:0] FS_RST   = 24'h500000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wipe,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    input  logic          data_taken,
    input  logic          conv_done,
    input  logic [DW-1:0] conv_result,
    output logic [DW-1:0] rd_word,
    output logic          rdy_n,
    output logic [15:0]   mode_q,
    output logic [15:0]   cfg_q,
    output logic [DW-1:0] ofs_q,
    output logic [DW-1:0] fs_q
);
    logic [DW-1:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_RST; cfg_q <= CFG_RST;
            ofs_q  <= OFS_RST;  fs_q  <= FS_RST;
            data_q <= '0;       rdy_n <= 1'b1;
        end else if (wipe) begin
            mode_q <= MODE_RST; cfg_q <= CFG_RST;
            ofs_q  <= OFS_RST;  fs_q  <= FS_RST;
            data_q <= '0;       rdy_n <= 1'b1;
        end else begin
            if (wr_en) begin
                case (wr_addr)
                    A_MODE:  mode_q <= wr_data[15:0];
                    A_CFG:   cfg_q  <= wr_data[15:0];
                    A_OFS:   ofs_q  <= wr_data;
                    A_FS:    fs_q   <= wr_data;
                    default: ;
                endcase
            end
            if (conv_done) begin
                data_q <= conv_result;
                rdy_n  <= 1'b0;
            end else if (data_taken || (wr_en && wr_addr == A_MODE)) begin
                rdy_n  <= 1'b1;
            end
        end
    end

    // read word, left aligned so the MSB always sits at bit DW-1
    always_comb begin
        case (rd_addr)
            A_STAT:  rd_word = {rdy_n, 7'b0, 16'b0};
            A_MODE:  rd_word = {mode_q, 8'b0};
            A_CFG:   rd_word = {cfg_q, 8'b0};
            A_DATA:  rd_word = data_q;
            A_ID:    rd_word = {ID_VALUE, 16'b0};
            A_OFS:   rd_word = ofs_q;
            A_FS:    rd_word = fs_q;
            default: rd_word = '0;
        endcase
    end
endmodule

// File: rtl/sif_cmd_port.sv
`timescale 1ns/1ps
module sif_cmd_port
    import sif_pkg::*;
#(
    parameter logic [7:0] ID_VALUE   = 8'hA7,
    parameter int          ONES_LIMIT = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk,
    input  logic          cs_n,
    input  logic          sdi,
    output logic          sdo,
    input  logic          conv_done,
    input  logic [DW-1:0] conv_result,
    output logic          rdy_n,
    output logic [15:0]   mode_q,
    output logic [15:0]   cfg_q,
    output logic [DW-1:0] ofs_q,
    output logic [DW-1:0] fs_q
);
    sif_state_e     state, state_d;
    logic [CNT_W-1:0] bit_cnt;
    logic [5:0]     cmd_sr;
    logic [AW-1:0]  addr_q;
    logic [DW-2:0]  rx_sr;
    logic [DW-1:0]  tx_sr;
    logic [7:0]     win;
    logic           sdo_q, crd_busy;
    logic           rise, fall, wipe;
    logic [DW-1:0]  rd_word;
    logic [AW-1:0]  rd_addr;
    logic           wr_en, data_taken;

    sif_edge u_edge (.clk(clk), .rst_n(rst_n), .sclk(sclk), .rise(rise), .fall(fall));

    sif_ones_watch #(.LIMIT(ONES_LIMIT)) u_ones (
        .clk(clk), .rst_n(rst_n), .rise(rise), .cs_n(cs_n), .sdi(sdi), .wipe(wipe)
    );

    // decoded command, valid on the rising edge that brings in bit 0
    logic          c_rd, c_cont, cmd_done, xfer_last, crd_exit;
    logic [AW-1:0] c_addr;
    logic [7:0]    win_d;

    assign c_rd      = cmd_sr[5];
    assign c_addr    = cmd_sr[4:2];
    assign c_cont    = cmd_sr[1] && !cmd_sr[0] && !sdi && c_rd && (c_addr == A_DATA);
    assign cmd_done  = (state == ST_CMD) && rise && (bit_cnt == CNT_W'(7));
    assign xfer_last = rise && (bit_cnt == reg_len(addr_q) - CNT_W'(1));
    assign win_d     = {win[6:0], sdi};
    assign crd_exit  = (state == ST_CRD) && rise && (win_d == CRD_EXIT) && !rdy_n;

    assign rd_addr    = (state == ST_CMD) ? c_addr : addr_q;
    assign wr_en      = !cs_n && !wipe && (state == ST_WR) && xfer_last;
    assign data_taken = !cs_n && !wipe &&
                        (((state == ST_RD) && xfer_last && (addr_q == A_DATA)) ||
                         ((state == ST_CRD) && crd_busy && rise && (bit_cnt == CNT_W'(DW - 1))));

    sif_regbank #(.ID_VALUE(ID_VALUE)) u_bank (
        .clk(clk), .rst_n(rst_n), .wipe(wipe),
        .wr_en(wr_en), .wr_addr(addr_q), .wr_data({rx_sr, sdi}),
        .rd_addr(rd_addr), .data_taken(data_taken),
        .conv_done(conv_done), .conv_result(conv_result),
        .rd_word(rd_word), .rdy_n(rdy_n),
        .mode_q(mode_q), .cfg_q(cfg_q), .ofs_q(ofs_q), .fs_q(fs_q)
    );

    // next-state logic
    always_comb begin
        state_d = state;
        if (!cs_n) begin
            unique case (state)
                ST_CMD: if (cmd_done) begin
                    if (c_cont)                state_d = ST_CRD;
                    else if (c_rd)             state_d = ST_RD;
                    else if (c_addr != A_STAT) state_d = ST_WR;
                end
                ST_RD, ST_WR: if (xfer_last) state_d = ST_CMD;
                ST_CRD:       if (crd_exit)  state_d = ST_CMD;
            endcase
        end else if (state != ST_CRD) begin
            state_d = ST_CMD;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    state <= ST_CMD;
        else if (wipe) state <= ST_CMD;
        else           state <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0; cmd_sr <= '0; addr_q <= '0; rx_sr <= '0;
            tx_sr <= '0; win <= '0; crd_busy <= 1'b0; sdo_q <= 1'b0;
        end else if (wipe) begin
            bit_cnt <= '0; cmd_sr <= '0; addr_q <= '0; rx_sr <= '0;
            tx_sr <= '0; win <= '0; crd_busy <= 1'b0;
        end else if (cs_n) begin
            bit_cnt <= '0; win <= '0; crd_busy <= 1'b0;
        end else begin
            if (fall) begin
                if (state == ST_CRD && !crd_busy && !rdy_n) begin
                    sdo_q    <= rd_word[DW-1];
                    tx_sr    <= {rd_word[DW-2:0], 1'b0};
                    crd_busy <= 1'b1;
                end else begin
                    sdo_q <= tx_sr[DW-1];
                    tx_sr <= {tx_sr[DW-2:0], 1'b0};
                end
            end
            if (rise) begin
                unique case (state)
                    ST_CMD: begin
                        if (bit_cnt == '0) begin
                            if (!sdi) bit_cnt <= CNT_W'(1);
                        end else if (cmd_done) begin
                            bit_cnt <= '0;
                            addr_q  <= c_addr;
                            win     <= '0;
                            if (c_rd && !c_cont) tx_sr <= rd_word;
                        end else begin
                            cmd_sr  <= {cmd_sr[4:0], sdi};
                            bit_cnt <= bit_cnt + CNT_W'(1);
                        end
                    end
                    ST_RD: bit_cnt <= xfer_last ? '0 : bit_cnt + CNT_W'(1);
                    ST_WR: begin
                        rx_sr   <= {rx_sr[DW-3:0], sdi};
                        bit_cnt <= xfer_last ? '0 : bit_cnt + CNT_W'(1);
                    end
                    ST_CRD: begin
                        win <= win_d;
                        if (crd_exit) begin
                            crd_busy <= 1'b0;
                            bit_cnt  <= '0;
                        end else if (crd_busy) begin
                            if (bit_cnt == CNT_W'(DW - 1)) begin
                                crd_busy <= 1'b0;
                                bit_cnt  <= '0;
                            end else begin
                                bit_cnt <= bit_cnt + CNT_W'(1);
                            end
                        end
                    end
                endcase
            end
        end
    end

    assign sdo = sdo_q;
endmodule

// File: rtl/sif_cmd_port_chk.sv
`timescale 1ns/1ps
module sif_cmd_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sclk,
    input logic        cs_n,
    input logic        sdo,
    input logic        rdy_n,
    input logic        conv_done,
    input logic        wipe,
    input logic [15:0] mode_q,
    input logic [15:0] cfg_q,
    input logic [23:0] ofs_q,
    input logic [23:0] fs_q
);
    logic sclk_d;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_d <= 1'b1;
        else        sclk_d <= sclk;
    end

    logic fall_seen;
    assign fall_seen = sclk_d && !sclk && !cs_n;

    // R11
    sdo_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_seen |=> $stable(sdo));

    // R5
    done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !wipe) |=> !rdy_n);

    // R8
    wipe_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wipe |=> (mode_q == 16'h000A) && rdy_n);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> ($stable(mode_q) && $stable(cfg_q) && $stable(ofs_q) && $stable(fs_q)));
endmodule

bind sif_cmd_port sif_cmd_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdo(sdo), .rdy_n(rdy_n),
    .conv_done(conv_done), .wipe(wipe), .mode_q(mode_q), .cfg_q(cfg_q),
    .ofs_q(ofs_q), .fs_q(fs_q)
);

// File: tb/sif_cmd_port_tb.sv
`timescale 1ns/1ps
module sif_cmd_port_tb;
    localparam logic [7:0] IDV = 8'hA7;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0, sclk = 1'b1, cs_n = 1'b1, sdi = 1'b0, conv_done = 1'b0;
    logic [23:0] conv_result = '0;
    logic sdo, rdy_n;
    logic [15:0] mode_q, cfg_q;
    logic [23:0] ofs_q, fs_q;

    sif_cmd_port #(.ID_VALUE(IDV)) u_dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi), .sdo(sdo),
        .conv_done(conv_done), .conv_result(conv_result), .rdy_n(rdy_n),
        .mode_q(mode_q), .cfg_q(cfg_q), .ofs_q(ofs_q), .fs_q(fs_q)
    );

    int checks = 0, fails = 0;
    bit finished = 1'b0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int blen(input logic [2:0] a);
        case (a)
            3'd1, 3'd2:       return 16;
            3'd3, 3'd6, 3'd7: return 24;
            default:          return 8;
        endcase
    endfunction

    function automatic logic [31:0] lmask(input int n);
        return (32'h1 << n) - 32'h1;
    endfunction

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sbit(input logic b, output logic o);
        @(negedge clk); sclk = 1'b0; sdi = b;
        clks(4); o = sdo;
        sclk = 1'b1;
        clks(4);
    endtask

    task automatic shift(input logic [31:0] v, input int n, output logic [31:0] r);
        logic o;
        r = '0;
        for (int i = n - 1; i >= 0; i--) begin
            sbit(v[i], o);
            r = {r[30:0], o};
        end
    endtask

    task automatic sel;   @(negedge clk); cs_n = 1'b0; clks(2); endtask
    task automatic desel; clks(2); sdi = 1'b0; cs_n = 1'b1; clks(4); endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] v, input int lead);
        logic [31:0] r;
        sel;
        if (lead > 0) shift(32'hFFFF_FFFF, lead, r);
        shift({24'b0, 2'b00, a, 3'b000}, 8, r);
        shift(v, blen(a), r);
        desel;
    endtask

    task automatic rd_reg(input logic [2:0] a, input int lead, output logic [31:0] v);
        logic [31:0] r;
        sel;
        if (lead > 0) shift(32'hFFFF_FFFF, lead, r);
        shift({24'b0, 2'b01, a, 3'b000}, 8, r);
        shift(32'h0, blen(a), v);
        desel;
    endtask

    task automatic pulse_done(input logic [23:0] v);
        @(negedge clk); conv_result = v; conv_done = 1'b1;
        @(negedge clk); conv_done = 1'b0;
        clks(2);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary;
            $finish;
        end
    end

    initial begin
        logic [31:0] r, v, pat;
        logic [2:0]  wa [4];
        wa[0] = 3'd1; wa[1] = 3'd2; wa[2] = 3'd6; wa[3] = 3'd7;

        clks(5); rst_n = 1'b1; clks(3);

        // R9 power-on state
        check("R9 rdy_n", {31'b0, rdy_n}, 32'h1);
        check("R9 mode", {16'b0, mode_q}, 32'h000A);
        check("R9 cfg", {16'b0, cfg_q}, 32'h0010);
        check("R9 ofs", {8'b0, ofs_q}, 32'h800000);
        check("R9 fs", {8'b0, fs_q}, 32'h500000);
        rd_reg(3'd0, 0, r); check("R9 status", r, 32'h80);

        // R4 fixed read-only contents
        rd_reg(3'd4, 0, r); check("R4 id", r, {24'b0, IDV});
        rd_reg(3'd5, 0, r); check("R4 reserved", r, 32'h0);

        // R1 leading ones sweep in the write-enable position
        for (int k = 0; k < 6; k++) begin
            wr_reg(3'd1, 32'h0100 + k, k);
            check("R1 gated write", {16'b0, mode_q}, 32'h0100 + k);
            rd_reg(3'd1, k, r);
            check("R1 gated read", r, 32'h0100 + k);
        end

        // R2 R3 writable registers under several patterns
        foreach (wa[j]) begin
            for (int p = 0; p < 4; p++) begin
                case (p)
                    0: pat = 32'hFFFF_FFFF;
                    1: pat = 32'h5555_5555;
                    2: pat = 32'hAAAA_AAAA;
                    default: pat = 32'h009E_3779 * (j + 3);
                endcase
                v = pat & lmask(blen(wa[j]));
                wr_reg(wa[j], v, 0);
                case (wa[j])
                    3'd1: check("R3 mode_q", {16'b0, mode_q}, v);
                    3'd2: check("R3 cfg_q", {16'b0, cfg_q}, v);
                    3'd6: check("R3 ofs_q", {8'b0, ofs_q}, v);
                    default: check("R3 fs_q", {8'b0, fs_q}, v);
                endcase
                rd_reg(wa[j], 0, r);
                check("R2 readback length", r, v);
            end
        end

        // R5 result capture and release by full read
        check("R5 idle ready", {31'b0, rdy_n}, 32'h1);
        pulse_done(24'hC3A55A);
        check("R5 ready low", {31'b0, rdy_n}, 32'h0);
        rd_reg(3'd0, 0, r); check("R4 status pending", r, 32'h00);
        // R4 writes to read-only addresses ignored
        wr_reg(3'd3, 32'h123456, 0);
        check("R4 data write rdy", {31'b0, rdy_n}, 32'h0);
        wr_reg(3'd4, 32'h00, 0);
        wr_reg(3'd5, 32'hFF, 0);
        rd_reg(3'd4, 0, r); check("R4 id after write", r, {24'b0, IDV});
        rd_reg(3'd5, 0, r); check("R4 rsv after write", r, 32'h0);
        rd_reg(3'd3, 0, r); check("R5 data read", r, 32'hC3A55A);
        check("R5 ready after read", {31'b0, rdy_n}, 32'h1);
        // R5 mode write releases ready
        pulse_done(24'h000001);
        check("R5 ready low 2", {31'b0, rdy_n}, 32'h0);
        wr_reg(3'd1, 32'h0022, 0);
        check("R5 mode write rdy", {31'b0, rdy_n}, 32'h1);

        // R4 write command to address 0 then a new command in the same frame
        sel;
        shift(32'h00, 8, r);
        shift(32'h48, 8, r);
        shift(32'h0, 16, r);
        desel;
        check("R4 addr0 write is command", r, 32'h0022);

        // R6 continuous read frames
        sel;
        shift(32'h5C, 8, r);
        for (int f = 0; f < 3; f++) begin
            v = (32'h00F0_0F0F ^ (32'h0013_579B * f)) & 32'h00FF_FFFF;
            pulse_done(v[23:0]);
            check("R6 ready low", {31'b0, rdy_n}, 32'h0);
            shift(32'h0, 24, r);
            check("R6 frame data", r, v);
            clks(2);
            check("R6 ready high", {31'b0, rdy_n}, 32'h1);
        end
        // R7 exit byte while ready high is ignored
        shift(32'h58, 8, r);
        pulse_done(24'h6B1D2E);
        shift(32'h0, 24, r);
        check("R7 ignore exit when ready high", r, 32'h6B1D2E);
        // R7 exit byte while ready low
        pulse_done(24'hA1B2C3);
        shift(32'h58, 8, r);
        check("R7 exit frame head", r, 32'hA1);
        desel;
        rd_reg(3'd0, 0, r); check("R7 status after exit", r, 32'h00);
        rd_reg(3'd3, 0, r); check("R7 normal data read", r, 32'hA1B2C3);
        check("R7 ready after read", {31'b0, rdy_n}, 32'h1);

        // R10 aborted partial transfers
        wr_reg(3'd1, 32'h1234, 0);
        sel; shift(32'h08, 8, r); shift(32'h55, 8, r); desel;
        check("R10 partial write", {16'b0, mode_q}, 32'h1234);
        sel; shift(32'h4, 4, r); desel;
        rd_reg(3'd4, 0, r); check("R10 command wait", r, {24'b0, IDV});

        // R8 31 ones then a zero: no reset
        sel; shift(32'hFFFF_FFFF, 31, r); shift(32'h0, 1, r); desel;
        check("R8 31 ones", {16'b0, mode_q}, 32'h1234);
        // R8 32 ones: full reset
        wr_reg(3'd2, 32'hBEEF, 0);
        wr_reg(3'd6, 32'h123456, 0);
        sel; shift(32'hFFFF_FFFF, 32, r); desel;
        check("R8 mode", {16'b0, mode_q}, 32'h000A);
        check("R8 cfg", {16'b0, cfg_q}, 32'h0010);
        check("R8 ofs", {8'b0, ofs_q}, 32'h800000);
        check("R8 fs", {8'b0, fs_q}, 32'h500000);
        rd_reg(3'd0, 0, r); check("R8 status", r, 32'h80);
        // R8 reset from continuous read
        wr_reg(3'd1, 32'h4321, 0);
        sel; shift(32'h5C, 8, r); shift(32'hFFFF_FFFF, 32, r); desel;
        check("R8 crd mode", {16'b0, mode_q}, 32'h000A);
        rd_reg(3'd4, 0, r); check("R8 crd left", r, {24'b0, IDV});

        finished = 1'b1;
        summary;
        $finish;
    end
endmodule